// File: doc/BRIEF.md
# Real-Time Clock Counter with Guarded Trim

This block keeps time for a chip from a single-cycle tick strobe. Each tick advances a 12-bit sub-second count. When that count passes from its all-ones value back to zero, a 32-bit count of whole seconds goes up by one. Software reads and writes both counts through a simple APB-style register port.

Crystal error is corrected with a signed 8-bit trim value. At each whole-second boundary the trim changes the length of the coming second. A positive value starts the sub-second count above zero, so the second is shorter. A negative value holds the sub-second count at zero for extra ticks, so the second is longer. In both cases the second lasts 4096 minus trim ticks.

Trim updates use a handshake. A write-enable bit in the control register must be set, and a busy flag blocks further writes while an accepted update settles. A ready flag tells software that the counters are coherent after a tick. An interrupt fires when ready is set and its enable bit is on.

Top module: `rtc_core`

## Requirements
- R1: After the synchronous active-high reset, every register reads 0, `prdata` is 0 and `irq` is 0.
- R2: The word at offset 0x00 is the whole-second count, 32 bits wide, and software can read and write it.
- R3: The word at offset 0x04 holds the sub-second count in bits 11:0. Software can read and write those bits. Bits 31:12 read 0, and writes to them are dropped.
- R4: A tick adds 1 to the sub-second count. A tick that finds the count at 0xFFF, with trim 0, sets it to 0 and adds 1 to the second count. No other event changes the second count, except a software write to it.
- R5: With a positive trim T, a tick that finds the count at 0xFFF adds 1 to the second count and loads T into the sub-second count.
- R6: With a negative trim −M, a tick that finds the count at 0xFFF adds 1 to the second count and sets the sub-second count to 0. The next M ticks then leave the sub-second count unchanged.
- R7: The control word is at offset 0x10, with these bits:
  - bit 0: ready flag.
  - bit 1: ready-interrupt enable.
  - bit 2: busy, read-only.
  - bit 3: trim write-enable.

  Writing 0 to bit 0 clears ready, and writing 1 to it does nothing. Hardware sets ready on the second clock edge after the edge that samples a tick, and this hardware set wins over a clear in the same cycle.
- R8: `irq` is 1 on the clock edge after both ready and the interrupt enable are 1. Otherwise it is 0.
- R9: The trim value is at offset 0x14, bits 7:0, and reads back zero-extended. A write to it takes effect only while write-enable is 1 and busy is 0. Otherwise the write is dropped.
- R10: An accepted trim write sets busy for exactly 2 clock cycles. Hardware then clears it.
- R11: Offsets 0x08, 0x0C, 0x18 and every other unmapped offset read 0, and writes to them change nothing.
- R12: Read data is captured in the APB setup phase and holds steady through the access phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| tick | input | 1 | Single-cycle sub-second advance strobe |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 5 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| irq | output | 1 | Registered ready interrupt |

## Verification
The bench builds the block with its default parameters: a 12-bit sub-second count, an 8-bit trim and a two-cycle busy window. Because the sub-second count can be written, a single tick after loading 0xFFF reaches every whole-second boundary, with zero, positive and negative trim. With a busy window of two cycles, the second write of a back-to-back APB pair lands inside that window. This shows that a trim write is dropped while busy.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // word indices (byte offset / 4)
  localparam int unsigned WI_SEC  = 0;
  localparam int unsigned WI_SSEC = 1;
  localparam int unsigned WI_CTRL = 4;
  localparam int unsigned WI_TRIM = 5;
  // control word bit positions
  localparam int unsigned CB_READY = 0;
  localparam int unsigned CB_IE    = 1;
  localparam int unsigned CB_BUSY  = 2;
  localparam int unsigned CB_WEN   = 3;
endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int SSEC_W = 12,
  parameter int TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr,
  input  logic [SSEC_W-1:0] wdata,
  input  logic [TRIM_W-1:0] trim,
  output logic [SSEC_W-1:0] ssec,
  output logic              wrap
);
  localparam int PAD_W = SSEC_W - TRIM_W;

  logic [SSEC_W-1:0] ssec_q;
  logic [TRIM_W-1:0] hold_q;
  logic [TRIM_W-1:0] neg_mag;
  logic [SSEC_W-1:0] pos_load;
  logic              hold_idle;

  assign hold_idle = (hold_q == '0);
  assign neg_mag   = '0 - trim;
  assign pos_load  = {{PAD_W{1'b0}}, trim};
  assign wrap      = tick && !wr && hold_idle && (ssec_q == '1);
  assign ssec      = ssec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ssec_q <= '0;
      hold_q <= '0;
    end else if (wr) begin
      ssec_q <= wdata;
      hold_q <= '0;
    end else if (tick) begin
      if (!hold_idle) begin
        hold_q <= hold_q - 1'b1;
      end else if (ssec_q == '1) begin
        if (trim[TRIM_W-1]) begin
          ssec_q <= '0;
          hold_q <= neg_mag;
        end else begin
          ssec_q <= pos_load;
        end
      end else begin
        ssec_q <= ssec_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_seccnt.sv
module rtc_seccnt #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEC_W-1:0] wdata,
  input  logic             inc,
  output logic [SEC_W-1:0] sec
);
  logic [SEC_W-1:0] sec_q;
  assign sec = sec_q;

  always_ff @(posedge clk) begin
    if (rst)      sec_q <= '0;
    else if (wr)  sec_q <= wdata;
    else if (inc) sec_q <= sec_q + 1'b1;
  end
endmodule

// File: rtl/rtc_trim.sv
module rtc_trim #(
  parameter int TRIM_W   = 8,
  parameter int BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              wen,
  input  logic [TRIM_W-1:0] wdata,
  output logic [TRIM_W-1:0] trim,
  output logic              busy,
  output logic              accept
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [TRIM_W-1:0] trim_q;

  assign busy   = (cnt_q != '0);
  assign accept = wr && wen && !busy;
  assign trim   = trim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trim_q <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      trim_q <= wdata;
      cnt_q  <= CNT_W'(BUSY_CYC);
    end else if (busy) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int SEC_W    = 32,
  parameter int SSEC_W   = 12,
  parameter int TRIM_W   = 8,
  parameter int BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);
  localparam int WIDX_W = ADDR_W - 2;

  logic              wr_stb, rd_stb;
  logic [WIDX_W-1:0] widx;
  logic              wr_sec, wr_ssec, wr_ctrl, wr_trim;
  logic [SEC_W-1:0]  sec_w;
  logic [SSEC_W-1:0] ssec_w;
  logic [TRIM_W-1:0] trim_w;
  logic              wrap_w, busy_w, trim_acc;
  logic              ready_q, ie_q, wen_q, tick_d, irq_q;
  logic [DATA_W-1:0] rd_word, prdata_q;

  assign wr_stb  = psel && penable && pwrite;
  assign rd_stb  = psel && !penable && !pwrite;
  assign widx    = paddr[ADDR_W-1:2];
  assign wr_sec  = wr_stb && (widx == WIDX_W'(WI_SEC));
  assign wr_ssec = wr_stb && (widx == WIDX_W'(WI_SSEC));
  assign wr_ctrl = wr_stb && (widx == WIDX_W'(WI_CTRL));
  assign wr_trim = wr_stb && (widx == WIDX_W'(WI_TRIM));

  rtc_subsec #(.SSEC_W(SSEC_W), .TRIM_W(TRIM_W)) u_sub (
    .clk(clk), .rst(rst), .tick(tick), .wr(wr_ssec),
    .wdata(pwdata[SSEC_W-1:0]), .trim(trim_w),
    .ssec(ssec_w), .wrap(wrap_w)
  );

  rtc_seccnt #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst(rst), .wr(wr_sec), .wdata(pwdata[SEC_W-1:0]),
    .inc(wrap_w), .sec(sec_w)
  );

  rtc_trim #(.TRIM_W(TRIM_W), .BUSY_CYC(BUSY_CYC)) u_trim (
    .clk(clk), .rst(rst), .wr(wr_trim), .wen(wen_q),
    .wdata(pwdata[TRIM_W-1:0]), .trim(trim_w), .busy(busy_w),
    .accept(trim_acc)
  );

  // control flags; hardware ready set has priority over a software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_d  <= 1'b0;
      ready_q <= 1'b0;
      ie_q    <= 1'b0;
      wen_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      tick_d <= tick;
      if (tick_d)                          ready_q <= 1'b1;
      else if (wr_ctrl && !pwdata[CB_READY]) ready_q <= 1'b0;
      if (wr_ctrl) begin
        ie_q  <= pwdata[CB_IE];
        wen_q <= pwdata[CB_WEN];
      end
      irq_q <= ready_q && ie_q;
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (widx)
      WIDX_W'(WI_SEC):  rd_word = DATA_W'(sec_w);
      WIDX_W'(WI_SSEC): rd_word = DATA_W'(ssec_w);
      WIDX_W'(WI_CTRL): begin
        rd_word[CB_READY] = ready_q;
        rd_word[CB_IE]    = ie_q;
        rd_word[CB_BUSY]  = busy_w;
        rd_word[CB_WEN]   = wen_q;
      end
      WIDX_W'(WI_TRIM): rd_word = DATA_W'(trim_w);
      default:          rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         prdata_q <= '0;
    else if (rd_stb) prdata_q <= rd_word;
  end

  assign prdata = prdata_q;
  assign irq    = irq_q;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int SEC_W    = 32,
  parameter int TRIM_W   = 8,
  parameter int BUSY_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wrap,
  input logic              wr_sec,
  input logic [SEC_W-1:0]  sec,
  input logic              wr_trim,
  input logic              wen,
  input logic              busy,
  input logic              trim_acc,
  input logic [TRIM_W-1:0] trim,
  input logic              ready,
  input logic              ie,
  input logic              irq
);
  localparam int RUN_W = $clog2(BUSY_CYC + 2) + 1;
  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  p_sec_step_r4: assert property (@(posedge clk) disable iff (rst)
    (wrap && !wr_sec) |=> (sec == $past(sec) + 1'b1));
  p_sec_still_r4: assert property (@(posedge clk) disable iff (rst)
    (!wrap && !wr_sec) |=> $stable(sec));
  p_ready_set_r7: assert property (@(posedge clk) disable iff (rst)
    tick |-> ##2 ready);
  p_irq_off_r8: assert property (@(posedge clk) disable iff (rst)
    !(ready && ie) |=> !irq);
  p_trim_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_trim && (!wen || busy)) |=> $stable(trim));
  p_busy_rise_r10: assert property (@(posedge clk) disable iff (rst)
    trim_acc |=> busy);
  p_busy_len_r10: assert property (@(posedge clk) disable iff (rst)
    busy_run <= RUN_W'(BUSY_CYC));
endmodule

bind rtc_core rtc_core_chk #(.SEC_W(SEC_W), .TRIM_W(TRIM_W), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wrap(wrap_w), .wr_sec(wr_sec), .sec(sec_w),
  .wr_trim(wr_trim), .wen(wen_q), .busy(busy_w), .trim_acc(trim_acc), .trim(trim_w),
  .ready(ready_q), .ie(ie_q), .irq(irq)
);

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_core u_rtc_core (
    .clk(clk), .rst(rst), .tick(tick), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  // op: 0 write, 1 read and compare, 2 tick
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 5'h00, 32'h1234_5678, 32'h0},          // R2
    {2'd1, 5'h00, 32'h0,         32'h1234_5678},  // R2
    {2'd0, 5'h04, 32'hABCD_E123, 32'h0},          // R3
    {2'd1, 5'h04, 32'h0,         32'h0000_0123},  // R3 reserved bits 0
    {2'd0, 5'h04, 32'h0000_0FFE, 32'h0},          // R4
    {2'd2, 5'h00, 32'h0,         32'h0},
    {2'd1, 5'h04, 32'h0,         32'h0000_0FFF},  // R4 plain step
    {2'd1, 5'h00, 32'h0,         32'h1234_5678},  // R4 no carry yet
    {2'd2, 5'h00, 32'h0,         32'h0},
    {2'd1, 5'h04, 32'h0,         32'h0},          // R4 wrap to 0
    {2'd1, 5'h00, 32'h0,         32'h1234_5679},  // R4 carry
    {2'd0, 5'h08, 32'hFFFF_FFFF, 32'h0},          // R11
    {2'd1, 5'h08, 32'h0,         32'h0},          // R11
    {2'd0, 5'h18, 32'hFFFF_FFFF, 32'h0},          // R11
    {2'd1, 5'h18, 32'h0,         32'h0},          // R11
    {2'd1, 5'h0C, 32'h0,         32'h0},          // R11
    {2'd1, 5'h1C, 32'h0,         32'h0}           // R11
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  // R12: data captured in setup, sampled in access phase
  task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic apb_wr_pair(input logic [4:0] a, input logic [31:0] d1, input logic [31:0] d2);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d1;
    @(negedge clk); penable = 1;
    @(negedge clk); penable = 0; pwdata = d2;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    apb_rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 prdata", prdata, 32'h0);
    rd_chk("R1 sec", 5'h00, 32'h0);
    rd_chk("R1 ssec", 5'h04, 32'h0);
    rd_chk("R1 ctrl", 5'h10, 32'h0);
    rd_chk("R1 trim", 5'h14, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      case (VEC[i][70:69])
        2'd0: apb_wr(VEC[i][68:64], VEC[i][63:32]);
        2'd1: begin
          apb_rd(VEC[i][68:64], v);
          check($sformatf("vec %0d", i), v, VEC[i][31:0]);
        end
        default: do_tick();
      endcase
    end

    // R7 ready handshake
    apb_wr(5'h10, 32'h0);
    rd_chk("R7 cleared", 5'h10, 32'h0);
    do_tick();
    rd_chk("R7 hw set", 5'h10, 32'h1);
    apb_wr(5'h10, 32'h0);
    rd_chk("R7 sw clear", 5'h10, 32'h0);
    apb_wr(5'h10, 32'h1);
    rd_chk("R7 sw set ignored", 5'h10, 32'h0);

    // R8 interrupt
    apb_wr(5'h10, 32'h2);
    check("R8 idle", {31'b0, irq}, 32'h0);
    do_tick();
    repeat (3) @(negedge clk);
    check("R8 raised", {31'b0, irq}, 32'h1);
    apb_wr(5'h10, 32'h2);
    @(negedge clk);
    check("R8 dropped", {31'b0, irq}, 32'h0);

    // R9 / R10 trim handshake
    apb_wr(5'h10, 32'h0);
    apb_wr(5'h14, 32'h05);
    rd_chk("R9 locked", 5'h14, 32'h0);
    apb_wr(5'h10, 32'h8);
    apb_wr(5'h14, 32'h05);
    rd_chk("R10 busy seen", 5'h10, 32'hC);
    rd_chk("R10 busy cleared", 5'h10, 32'h8);
    rd_chk("R9 accepted", 5'h14, 32'h05);
    apb_wr_pair(5'h14, 32'h07, 32'h09);
    rd_chk("R9 busy blocks", 5'h14, 32'h07);

    // R5 positive trim
    apb_wr(5'h00, 32'h0);
    apb_wr(5'h04, 32'hFFF);
    do_tick();
    rd_chk("R5 ssec", 5'h04, 32'h7);
    rd_chk("R5 sec", 5'h00, 32'h1);

    // R6 negative trim (-3)
    apb_wr(5'h14, 32'hFD);
    rd_chk("R6 trim", 5'h14, 32'hFD);
    apb_wr(5'h04, 32'hFFF);
    do_tick();
    rd_chk("R6 ssec zero", 5'h04, 32'h0);
    rd_chk("R6 sec", 5'h00, 32'h2);
    repeat (3) do_tick();
    rd_chk("R6 held", 5'h04, 32'h0);
    do_tick();
    rd_chk("R6 resumes", 5'h04, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule